// File: doc/BRIEF.md
# Pipelined Saturating Fixed-Point Divider

This block divides one signed two's-complement fixed-point number by another and returns a signed fixed-point quotient. A word's value is its two's-complement integer scaled down by 2 raised to its fractional width. Operand A, operand B and the quotient each take their own integer and fractional widths from parameters, so the divider can sit between datapaths of unlike formats without extra alignment logic around it.

The datapath is fully pipelined. It takes a new operand pair on every clock in which `in_valid` is high and never stalls. Each result leaves a fixed number of cycles later, which is the quotient's total width plus three. The result comes with a copy of the valid bit and an overflow flag. A quotient that does not fit the output format is clamped to the nearest end of the range. A parameter selects whether the quotient bits below the output LSB are rounded to nearest or simply dropped.

Top module: `fxdiv_pipe`

## Requirements
- R1: With `in_valid` high, `q_out` holds the quotient A/B. Each operand is read as its two's-complement integer over 2^(its fractional width), and the result is encoded the same way with `Q_FRAC` fractional bits.
- R2: `out_valid` repeats `in_valid` exactly `Q_INT+Q_FRAC+3` clock edges later, and `q_out` and `ovf_out` belong to that same operand pair.
- R3: Operand pairs presented on consecutive cycles are all accepted, and each returns its own result on consecutive cycles with no stall or mixing.
- R4: With `ROUND=1`, the magnitude of the quotient is rounded to the nearest output LSB, and exact halves go away from zero. For example, (1/256)/2 gives +1 LSB and (-1/256)/2 gives -1 LSB.
- R5: With `ROUND=0`, the magnitude is truncated toward zero. For example, 2/3 in 8.8 format gives 0x00AA and -2/3 gives 0xFF56.
- R6: When the quotient is positive and above the largest output value, `ovf_out` is 1 and `q_out` is a 0 followed by all ones (0x7FFF in 8.8 format).
- R7: When the quotient is negative and below the most negative output value, `ovf_out` is 1 and `q_out` is a 1 followed by all zeros (0x8000 in 8.8 format). A quotient equal to that value is not an overflow.
- R8: When B is zero, `ovf_out` is 1 and `q_out` saturates by the sign of A. A non-negative A, including zero, gives the largest value and a negative A gives the most negative value.
- R9: A zero dividend with a non-zero divisor gives `q_out` = 0 and `ovf_out` = 0.
- R10: Synchronous reset clears `out_valid`, `q_out` and `ovf_out` at the next edge. No result from an operand pair accepted before the reset ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `a_in`/`b_in` is valid this cycle |
| a_in | input | A_INT+A_FRAC | Dividend, signed fixed point |
| b_in | input | B_INT+B_FRAC | Divisor, signed fixed point |
| out_valid | output | 1 | Result on `q_out`/`ovf_out` is valid |
| q_out | output | Q_INT+Q_FRAC | Quotient, signed fixed point, saturated |
| ovf_out | output | 1 | Quotient was outside the output range or B was zero |

## Verification
The last stage settles rounding, sign and saturation in the same cycle. Those three meet at the ends of the range, so the bench divides to land exactly on -128.0 (no overflow) and just past it (overflow). It also divides to +128.0 (overflow), and runs the same pairs through a rounding and a truncating instance side by side. Divide-by-zero and zero-dividend pairs are sent back-to-back with ordinary divisions. That way a saturated result and a rounded one leave on adjacent cycles. Every result is matched by issue cycle against a value computed in the bench from the requirements.

// File: rtl/fxdiv_pkg.sv
`timescale 1ns/1ps
package fxdiv_pkg;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_POS  = 2'd1,
    SAT_NEG  = 2'd2
  } sat_e;

endpackage

// File: rtl/fxdiv_prep.sv
`timescale 1ns/1ps
// Stage 0: operand magnitudes, binary-point alignment, sign and range pre-check.
module fxdiv_prep #(
  parameter int AW = 16,
  parameter int BW = 16,
  parameter int SH = 9,
  parameter int DW = 16,
  parameter int RW = 34,
  parameter int QB = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic          valid_o,
  output logic [RW-1:0] rem_o,
  output logic [DW-1:0] den_o,
  output logic          neg_o,
  output logic          sa_o,
  output logic          dz_o,
  output logic          ovf_o
);

  logic [AW-1:0] mag_a;
  logic [BW-1:0] mag_b;
  logic [RW-1:0] num_c;
  logic [DW-1:0] den_c;
  logic          pre_ovf;

  always_comb begin
    mag_a = a_i[AW-1] ? (~a_i + AW'(1)) : a_i;
    mag_b = b_i[BW-1] ? (~b_i + BW'(1)) : b_i;
  end

  // Place the binary points so that the integer quotient carries
  // Q_FRAC+1 fractional bits (one extra for rounding).
  generate
    if (SH >= 0) begin : g_shift_num
      assign num_c = RW'(mag_a) << SH;
      assign den_c = DW'(mag_b);
    end else begin : g_shift_den
      localparam int NSH = -SH;
      assign num_c = RW'(mag_a);
      assign den_c = DW'(mag_b) << NSH;
    end
  endgenerate

  // Quotient needs more than QB bits -> out of range before any step runs.
  assign pre_ovf = num_c >= (RW'(den_c) << QB);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      rem_o   <= '0;
      den_o   <= '0;
      neg_o   <= 1'b0;
      sa_o    <= 1'b0;
      dz_o    <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      rem_o   <= num_c;
      den_o   <= den_c;
      neg_o   <= a_i[AW-1] ^ b_i[BW-1];
      sa_o    <= a_i[AW-1];
      dz_o    <= (b_i == '0);
      ovf_o   <= pre_ovf;
    end
  end

endmodule

// File: rtl/fxdiv_step.sv
`timescale 1ns/1ps
// One restoring shift-subtract stage producing quotient bit K.
module fxdiv_step #(
  parameter int RW = 34,
  parameter int DW = 16,
  parameter int QB = 17,
  parameter int K  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [RW-1:0] rem_i,
  input  logic [DW-1:0] den_i,
  input  logic [QB-1:0] qacc_i,
  input  logic          neg_i,
  input  logic          sa_i,
  input  logic          dz_i,
  input  logic          ovf_i,
  output logic          valid_o,
  output logic [RW-1:0] rem_o,
  output logic [DW-1:0] den_o,
  output logic [QB-1:0] qacc_o,
  output logic          neg_o,
  output logic          sa_o,
  output logic          dz_o,
  output logic          ovf_o
);

  logic [RW-1:0] trial;
  logic          take;
  logic [QB-1:0] qacc_n;

  always_comb begin
    trial     = RW'(den_i) << K;
    take      = rem_i >= trial;
    qacc_n    = qacc_i;
    qacc_n[K] = take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      rem_o   <= '0;
      den_o   <= '0;
      qacc_o  <= '0;
      neg_o   <= 1'b0;
      sa_o    <= 1'b0;
      dz_o    <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      rem_o   <= take ? (rem_i - trial) : rem_i;
      den_o   <= den_i;
      qacc_o  <= qacc_n;
      neg_o   <= neg_i;
      sa_o    <= sa_i;
      dz_o    <= dz_i;
      ovf_o   <= ovf_i;
    end
  end

  // R1: partial remainder must drop below the next divisor multiple
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ovf_o && !dz_o) |-> (rem_o < (RW'(den_o) << K)));

  // R2: valid advances exactly one stage per edge
  a_r2_valid_step: assert property (@(posedge clk) disable iff (rst)
    valid_o == ($past(valid_i) && !$past(rst)));

endmodule

// File: rtl/fxdiv_finish.sv
`timescale 1ns/1ps
// Final stage: rounding, sign application and saturation.
module fxdiv_finish
  import fxdiv_pkg::*;
#(
  parameter int QW    = 16,
  parameter int QB    = 17,
  parameter bit ROUND = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [QB-1:0] qacc_i,
  input  logic          neg_i,
  input  logic          sa_i,
  input  logic          dz_i,
  input  logic          ovf_i,
  output logic          valid_o,
  output logic [QW-1:0] q_o,
  output logic          ovf_o
);

  localparam logic [QB-1:0] POS_LIM = {2'b00, {(QW-1){1'b1}}};
  localparam logic [QB-1:0] NEG_LIM = {2'b01, {(QW-1){1'b0}}};
  localparam logic [QW-1:0] MAXQ    = {1'b0, {(QW-1){1'b1}}};
  localparam logic [QW-1:0] MINQ    = {1'b1, {(QW-1){1'b0}}};

  logic [QB-1:0] mag;
  logic [QW-1:0] signed_q;
  sat_e          sat;

  always_comb begin
    mag      = {1'b0, qacc_i[QB-1:1]} + QB'(ROUND ? qacc_i[0] : 1'b0);
    signed_q = neg_i ? (~mag[QW-1:0] + QW'(1)) : mag[QW-1:0];
    if (dz_i)
      sat = sa_i ? SAT_NEG : SAT_POS;
    else if (ovf_i)
      sat = neg_i ? SAT_NEG : SAT_POS;
    else if (!neg_i && (mag > POS_LIM))
      sat = SAT_POS;
    else if (neg_i && (mag > NEG_LIM))
      sat = SAT_NEG;
    else
      sat = SAT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      q_o     <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= (sat != SAT_NONE);
      case (sat)
        SAT_POS: q_o <= MAXQ;
        SAT_NEG: q_o <= MINQ;
        default: q_o <= signed_q;
      endcase
    end
  end

  // R6 / R7: a flagged result is always one of the two range ends
  a_r6_sat_value: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> ((q_o == MAXQ) || (q_o == MINQ)));

  // R8: zero divisor always leaves with overflow set
  a_r8_div_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dz_i) |=> (valid_o && ovf_o));

  // R9: zero quotient accumulator in range gives a clean zero
  a_r9_zero_out: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !dz_i && !ovf_i && (qacc_i == '0)) |=> (!ovf_o && (q_o == '0)));

endmodule

// File: rtl/fxdiv_pipe.sv
`timescale 1ns/1ps
module fxdiv_pipe
  import fxdiv_pkg::*;
#(
  parameter int A_INT = 8,
  parameter int A_FRAC = 8,
  parameter int B_INT = 8,
  parameter int B_FRAC = 8,
  parameter int Q_INT = 8,
  parameter int Q_FRAC = 8,
  parameter bit ROUND = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [A_INT+A_FRAC-1:0] a_in,
  input  logic [B_INT+B_FRAC-1:0] b_in,
  output logic                    out_valid,
  output logic [Q_INT+Q_FRAC-1:0] q_out,
  output logic                    ovf_out
);

  localparam int AW = A_INT + A_FRAC;
  localparam int BW = B_INT + B_FRAC;
  localparam int QW = Q_INT + Q_FRAC;
  localparam int QB = QW + 1;
  localparam int SH = B_FRAC + Q_FRAC + 1 - A_FRAC;
  localparam int NW = AW + imax(SH, 0);
  localparam int DW = BW + imax(-SH, 0);
  localparam int RW = imax(NW, DW + QB) + 1;

  logic          v_s   [0:QB];
  logic [RW-1:0] rem_s [0:QB];
  logic [DW-1:0] den_s [0:QB];
  logic [QB-1:0] qa_s  [0:QB];
  logic          neg_s [0:QB];
  logic          sa_s  [0:QB];
  logic          dz_s  [0:QB];
  logic          ovf_s [0:QB];

  assign qa_s[0] = '0;

  fxdiv_prep #(
    .AW(AW), .BW(BW), .SH(SH), .DW(DW), .RW(RW), .QB(QB)
  ) u_prep (
    .clk(clk), .rst(rst), .valid_i(in_valid), .a_i(a_in), .b_i(b_in),
    .valid_o(v_s[0]), .rem_o(rem_s[0]), .den_o(den_s[0]),
    .neg_o(neg_s[0]), .sa_o(sa_s[0]), .dz_o(dz_s[0]), .ovf_o(ovf_s[0])
  );

  generate
    for (genvar s = 0; s < QB; s++) begin : g_step
      fxdiv_step #(
        .RW(RW), .DW(DW), .QB(QB), .K(QB - 1 - s)
      ) u_step (
        .clk(clk), .rst(rst),
        .valid_i(v_s[s]), .rem_i(rem_s[s]), .den_i(den_s[s]), .qacc_i(qa_s[s]),
        .neg_i(neg_s[s]), .sa_i(sa_s[s]), .dz_i(dz_s[s]), .ovf_i(ovf_s[s]),
        .valid_o(v_s[s+1]), .rem_o(rem_s[s+1]), .den_o(den_s[s+1]), .qacc_o(qa_s[s+1]),
        .neg_o(neg_s[s+1]), .sa_o(sa_s[s+1]), .dz_o(dz_s[s+1]), .ovf_o(ovf_s[s+1])
      );
    end
  endgenerate

  fxdiv_finish #(
    .QW(QW), .QB(QB), .ROUND(ROUND)
  ) u_finish (
    .clk(clk), .rst(rst),
    .valid_i(v_s[QB]), .qacc_i(qa_s[QB]), .neg_i(neg_s[QB]), .sa_i(sa_s[QB]),
    .dz_i(dz_s[QB]), .ovf_i(ovf_s[QB]),
    .valid_o(out_valid), .q_o(q_out), .ovf_o(ovf_out)
  );

  // R10: reset clears the visible result on the next edge
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !ovf_out && (q_out == '0)));

endmodule

// File: tb/sim_fxdiv_pipe.sv
`timescale 1ns/1ps
module sim_fxdiv_pipe;

  localparam int LAT = 19;
  localparam int SHB = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        ov0, ov1, of0, of1;
  logic [15:0] q0, q1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [15:0] e0;
    logic        o0;
    logic [15:0] e1;
    logic        o1;
    int          at;
    string       tag;
  } exp_t;

  exp_t expq[$];
  exp_t cur;

  fxdiv_pipe #(.ROUND(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a), .b_in(b),
    .out_valid(ov0), .q_out(q0), .ovf_out(of0));

  fxdiv_pipe #(.ROUND(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a), .b_in(b),
    .out_valid(ov1), .q_out(q1), .ovf_out(of1));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference quotient built from the requirement text (8.8 / 8.8 -> 8.8).
  task automatic model(input logic [15:0] ia, input logic [15:0] ib, input bit rnd,
                       output logic [15:0] q, output logic o);
    longint na, nb, q2, m;
    bit neg;
    if (ib == 16'h0) begin
      o = 1'b1;
      q = ia[15] ? 16'h8000 : 16'h7FFF;
    end else begin
      na  = ia[15] ? -longint'($signed(ia)) : longint'(ia);
      nb  = ib[15] ? -longint'($signed(ib)) : longint'(ib);
      q2  = (na * (64'd1 << SHB)) / nb;
      m   = rnd ? ((q2 + 1) >> 1) : (q2 >> 1);
      neg = ia[15] ^ ib[15];
      if (!neg && m > 32767)      begin o = 1'b1; q = 16'h7FFF; end
      else if (neg && m > 32768)  begin o = 1'b1; q = 16'h8000; end
      else begin o = 1'b0; q = neg ? 16'(-m) : 16'(m); end
    end
  endtask

  task automatic push(input logic [15:0] ia, input logic [15:0] ib,
                      input logic [15:0] e0, input logic o0,
                      input logic [15:0] e1, input logic o1, input string tag);
    exp_t x;
    @(negedge clk);
    a = ia; b = ib; in_valid = 1'b1;
    x.e0 = e0; x.o0 = o0; x.e1 = e1; x.o1 = o1; x.at = cyc; x.tag = tag;
    expq.push_back(x);
  endtask

  task automatic issue_h(input logic [15:0] ia, input logic [15:0] ib,
                         input logic [15:0] e0, input logic o0,
                         input logic [15:0] e1, input logic o1, input string tag);
    push(ia, ib, e0, o0, e1, o1, tag);
  endtask

  task automatic issue_m(input logic [15:0] ia, input logic [15:0] ib, input string tag);
    logic [15:0] e0, e1;
    logic o0, o1;
    model(ia, ib, 1'b1, e0, o0);
    model(ia, ib, 1'b0, e1, o1);
    push(ia, ib, e0, o0, e1, o1, tag);
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  // Output monitor: matches each result to its issue cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (ov0 !== ov1) check(1'b0, "R2 instances disagree on valid", ov0, ov1);
      if (ov0) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          cur = expq.pop_front();
          check(cyc - cur.at == LAT, {"R2 latency ", cur.tag}, cyc - cur.at, LAT);
          check(q0 == cur.e0, {cur.tag, " round q"}, q0, cur.e0);
          check(of0 == cur.o0, {cur.tag, " round ovf"}, of0, cur.o0);
          check(q1 == cur.e1, {cur.tag, " trunc q"}, q1, cur.e1);
          check(of1 == cur.o1, {cur.tag, " trunc ovf"}, of1, cur.o1);
        end
      end
    end
  end

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check(ov0 == 1'b0 && ov1 == 1'b0, "R10 valid in reset", ov0, 0);
    check(q0 == 16'h0 && q1 == 16'h0, "R10 q in reset", q0, 0);
    check(of0 == 1'b0 && of1 == 1'b0, "R10 ovf in reset", of0, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_basic();  // R1
    issue_h(16'h0100, 16'h0200, 16'h0080, 0, 16'h0080, 0, "R1 1/2");
    issue_h(16'h1000, 16'hFC00, 16'hFC00, 0, 16'hFC00, 0, "R1 16/-4");
    issue_h(16'hF000, 16'hFC00, 16'h0400, 0, 16'h0400, 0, "R1 -16/-4");
    issue_h(16'h3FFF, 16'h0080, 16'h7FFE, 0, 16'h7FFE, 0, "R1 near max");
    drain("R1 drain");
  endtask

  task automatic t_round();  // R4 and R5
    issue_h(16'h0200, 16'h0300, 16'h00AB, 0, 16'h00AA, 0, "R4 R5 2/3");
    issue_h(16'hFE00, 16'h0300, 16'hFF55, 0, 16'hFF56, 0, "R4 R5 -2/3");
    issue_h(16'h0001, 16'h0200, 16'h0001, 0, 16'h0000, 0, "R4 R5 +half");
    issue_h(16'hFFFF, 16'h0200, 16'hFFFF, 0, 16'h0000, 0, "R4 R5 -half");
    issue_h(16'h0100, 16'h0300, 16'h0055, 0, 16'h0055, 0, "R4 R5 1/3");
    drain("R4 drain");
  endtask

  task automatic t_pos_ovf();  // R6
    issue_h(16'h6400, 16'h0080, 16'h7FFF, 1, 16'h7FFF, 1, "R6 100/0.5");
    issue_h(16'h4000, 16'h0080, 16'h7FFF, 1, 16'h7FFF, 1, "R6 exactly +128");
    issue_h(16'h7FFF, 16'h0001, 16'h7FFF, 1, 16'h7FFF, 1, "R6 huge");
    issue_h(16'h8000, 16'hFF00, 16'h7FFF, 1, 16'h7FFF, 1, "R6 min/-1");
    drain("R6 drain");
  endtask

  task automatic t_neg_ovf();  // R7
    issue_h(16'h9C00, 16'h0080, 16'h8000, 1, 16'h8000, 1, "R7 -100/0.5");
    issue_h(16'hC000, 16'h0080, 16'h8000, 0, 16'h8000, 0, "R7 exactly -128");
    issue_h(16'h4000, 16'hFF80, 16'h8000, 0, 16'h8000, 0, "R7 64/-0.5");
    issue_h(16'h4001, 16'hFF80, 16'h8000, 1, 16'h8000, 1, "R7 just past min");
    drain("R7 drain");
  endtask

  task automatic t_div_zero();  // R8, mixed with ordinary divisions
    issue_h(16'h0100, 16'h0000, 16'h7FFF, 1, 16'h7FFF, 1, "R8 +1/0");
    issue_h(16'h0200, 16'h0300, 16'h00AB, 0, 16'h00AA, 0, "R8 neighbour 2/3");
    issue_h(16'hFF00, 16'h0000, 16'h8000, 1, 16'h8000, 1, "R8 -1/0");
    issue_h(16'h0000, 16'h0000, 16'h7FFF, 1, 16'h7FFF, 1, "R8 0/0");
    drain("R8 drain");
  endtask

  task automatic t_zero_div();  // R9
    issue_h(16'h0000, 16'hFD00, 16'h0000, 0, 16'h0000, 0, "R9 0/-3");
    issue_h(16'h0000, 16'h0001, 16'h0000, 0, 16'h0000, 0, "R9 0/lsb");
    drain("R9 drain");
  endtask

  task automatic t_stream();  // R3
    logic [15:0] lf = 16'hACE1;
    logic [15:0] va;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      va = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      issue_m(va, (i % 17 == 0) ? 16'h0000 : {{4{lf[15]}}, lf[11:0]}, "R3 stream");
    end
    drain("R3 drain");
  endtask

  task automatic t_mid_reset();  // R10
    for (int i = 1; i <= 5; i++) issue_m(16'(i * 256), 16'h0300, "R10 pre-reset");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(ov0 == 1'b0, "R10 valid after reset", ov0, 0);
    check(q0 == 16'h0 && q1 == 16'h0, "R10 q after reset", q0, 0);
    check(of0 == 1'b0, "R10 ovf after reset", of0, 0);
    expq.delete();
    @(negedge clk);
    rst = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    check(expq.size() == 0, "R10 no stale result", expq.size(), 0);
    issue_h(16'h0100, 16'h0200, 16'h0080, 0, 16'h0080, 0, "R10 after reset");
    drain("R10 drain");
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_basic();
    t_round();
    t_pos_ovf();
    t_neg_ovf();
    t_div_zero();
    t_zero_div();
    t_stream();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule